// File: doc/BRIEF.md
# Host Command and Interrupt Status Unit

This unit sits between a byte-wide host register port and a bus protocol engine for a parallel SCSI initiator. The host writes 8-bit command bytes. The unit sorts each byte into one of four groups: commands it handles itself, commands it forwards to the engine as a one-cycle pulse, a chip-reset request, and undefined codes. It also holds a small byte FIFO that the host fills and the engine drains. The host can empty that FIFO with a flush command.

The engine reports its current bus phase and single-cycle event pulses: bus reset, disconnect, target service request, parity fault and gross fault. The unit latches each event as a cause and drives one interrupt line while any cause is held. The host has four registers to look at. The status register combines the phase code with the error flags and the pending-interrupt flag. The interrupt register shows the event causes, and reading it clears every latched cause. The count register shows the FIFO fill level.

After a chip-reset command the unit waits in a recovery state until the host writes a no-op. Any other command written during that time is dropped.

Top module: `hcu_top`

## Requirements
- R1: A write to address 1 whose low 7 bits are 0x03, 0x10, 0x11, 0x12, 0x1A, 0x1B or 0x41 raises `eng_cmd_valid` for exactly the one cycle after the write. In that cycle `eng_cmd_code` carries the low 7 bits and `eng_cmd_dma` carries bit 7 (so 0x90 is 0x10 with the DMA flag set).
- R2: Writes of 0x00 (no-op) and 0x01 (flush) to address 1 never raise `eng_cmd_valid`. A flush sets the FIFO count to 0 in the cycle after the write.
- R3: A command byte whose low 7 bits match no defined code (for example 0xFF) latches the bad-command cause. That cause is interrupt-register bit 6, and it sets status bit 7 and `irq` in the cycle after the write.
- R4: Status register bits [2:0] show the `eng_phase` value sampled at the previous clock edge, using these codes: 0 data-out, 1 data-in, 2 command, 3 status, 4 and 5 reserved, 6 message-out, 7 message-in. Status bits 4 and 3 always read 0.
- R5: An `eng_parity_err` pulse latches status bit 5. An `eng_gross_err` pulse latches status bit 6. Either one raises `irq` and status bit 7.
- R6: Engine pulses latch into the interrupt register as follows: `eng_bus_reset` sets bit 7, `eng_disconnect` sets bit 5 and `eng_service_req` sets bit 4. Bits 3 to 0 read 0. Each of these also raises `irq`.
- R7: A host read of address 2 returns the latched causes. At the next clock edge it clears every cause, including the status error bits, and so drops `irq`. A cause pulse that arrives in the same cycle as the read stays latched.
- R8: A write of 0x02 empties the FIFO, clears all causes and enters recovery. While in recovery, every write to address 1 except 0x00 is ignored: it gives no engine pulse, latches no cause and does not flush. A 0x00 write ends recovery.
- R9: A write to address 0 pushes a byte unless the FIFO holds DEPTH bytes. A read of address 0 or an `eng_pop` removes the oldest byte. Bytes leave in the order they were written.
- R10: Address 3 reads the FIFO count in bits [4:0], with the upper bits 0. `eng_head` shows the oldest byte, or 0 when the FIFO is empty.
- R11: After reset, `irq` is low, the count is 0, the status register reads 0 and `eng_cmd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Register select: 0 FIFO data, 1 command (write) or status (read), 2 interrupt causes, 3 FIFO count |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Selected register value, combinational |
| irq | output | 1 | High while any cause is latched |
| eng_phase | input | 3 | Current bus phase from the engine |
| eng_bus_reset | input | 1 | Bus reset seen (pulse) |
| eng_disconnect | input | 1 | Target disconnected (pulse) |
| eng_service_req | input | 1 | Target requests information transfer (pulse) |
| eng_parity_err | input | 1 | Parity fault (pulse) |
| eng_gross_err | input | 1 | Gross protocol fault (pulse) |
| eng_pop | input | 1 | Engine takes the oldest FIFO byte |
| eng_head | output | 8 | Oldest FIFO byte, 0 when empty |
| eng_cmd_valid | output | 1 | One-cycle command pulse to the engine |
| eng_cmd_code | output | 7 | Command code without the DMA bit |
| eng_cmd_dma | output | 1 | DMA qualifier of the forwarded command |

## Verification
The checker module looks at every cycle for the following:
- every engine pulse is traced back to a command write one cycle earlier;
- recovery suppresses the pulse;
- a flush outside recovery empties the FIFO;
- the status phase field follows the engine's phase with a one-cycle delay;
- the FIFO count never exceeds DEPTH;
- an interrupt-register read with no competing event drops `irq`.

The directed scenarios cover what a single property cannot show. These are the exact bit positions that each engine event and each command byte produce, and the survival of a cause that arrives in the same cycle as the read that clears it. They also include the full chip-reset recovery sequence, with an undefined code written during recovery, and first-in first-out ordering across host and engine pops.

// File: rtl/hcu_pkg.sv
package hcu_pkg;

    typedef enum logic [1:0] {
        RA_FIFO     = 2'd0,
        RA_CMD_STAT = 2'd1,
        RA_INTR     = 2'd2,
        RA_COUNT    = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        CK_NOP,
        CK_FLUSH,
        CK_CHIPRST,
        CK_ENGINE,
        CK_BAD
    } cmd_kind_e;

    // latched interrupt and error causes
    typedef struct packed {
        logic bus_rst;
        logic bad_cmd;
        logic disconn;
        logic svc_req;
        logic parity;
        logic gross;
    } cause_t;

    localparam int unsigned CAUSE_W = $bits(cause_t);

    function automatic cmd_kind_e classify(input logic [6:0] op);
        case (op)
            7'h00:   return CK_NOP;
            7'h01:   return CK_FLUSH;
            7'h02:   return CK_CHIPRST;
            7'h03, 7'h10, 7'h11, 7'h12,
            7'h1A, 7'h1B, 7'h41: return CK_ENGINE;
            default: return CK_BAD;
        endcase
    endfunction

endpackage

// File: rtl/hcu_cmd_decode.sv
module hcu_cmd_decode
    import hcu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_cmd,
    input  logic [7:0] cmd_byte,
    output logic       flush_o,
    output logic       chiprst_o,
    output logic       bad_o,
    output logic       recov_o,
    output logic       pulse_o,
    output logic [6:0] code_o,
    output logic       dma_o
);
    cmd_kind_e kind;
    logic      accept;
    logic      recov_q;

    assign kind      = classify(cmd_byte[6:0]);
    assign accept    = wr_cmd && (!recov_q || kind == CK_NOP);
    assign flush_o   = accept && kind == CK_FLUSH;
    assign chiprst_o = accept && kind == CK_CHIPRST;
    assign bad_o     = accept && kind == CK_BAD;
    assign recov_o   = recov_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            recov_q <= 1'b0;
            pulse_o <= 1'b0;
            code_o  <= '0;
            dma_o   <= 1'b0;
        end else begin
            if (chiprst_o)
                recov_q <= 1'b1;
            else if (accept && kind == CK_NOP)
                recov_q <= 1'b0;
            pulse_o <= accept && kind == CK_ENGINE;
            if (accept && kind == CK_ENGINE) begin
                code_o <= cmd_byte[6:0];
                dma_o  <= cmd_byte[7];
            end
        end
    end
endmodule

// File: rtl/hcu_byte_fifo.sv
module hcu_byte_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 8,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop, full, empty;

    assign full    = count == CW'(DEPTH);
    assign empty   = count == '0;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = empty ? '0 : mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/hcu_cause_latch.sv
module hcu_cause_latch #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] q
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q[b] <= 1'b0;
            else
                q[b] <= set_i[b] || (q[b] && !clr_i);
        end
    end
endmodule

// File: rtl/hcu_top.sv
module hcu_top
    import hcu_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16,
    localparam int unsigned CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [1:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       irq,
    input  logic [2:0] eng_phase,
    input  logic       eng_bus_reset,
    input  logic       eng_disconnect,
    input  logic       eng_service_req,
    input  logic       eng_parity_err,
    input  logic       eng_gross_err,
    input  logic       eng_pop,
    output logic [7:0] eng_head,
    output logic       eng_cmd_valid,
    output logic [6:0] eng_cmd_code,
    output logic       eng_cmd_dma
);
    logic          flush, chiprst, bad_cmd, recov;
    logic [2:0]    phase_q;
    logic [CW-1:0] count;
    cause_t        set_c, held;
    logic [7:0]    stat_reg, intr_reg;

    hcu_cmd_decode u_dec (
        .clk(clk), .rst(rst),
        .wr_cmd(host_wr && host_addr == RA_CMD_STAT),
        .cmd_byte(host_wdata),
        .flush_o(flush), .chiprst_o(chiprst), .bad_o(bad_cmd), .recov_o(recov),
        .pulse_o(eng_cmd_valid), .code_o(eng_cmd_code), .dma_o(eng_cmd_dma)
    );

    hcu_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst(rst),
        .flush(flush || chiprst),
        .push(host_wr && host_addr == RA_FIFO),
        .wdata(host_wdata),
        .pop(eng_pop || (host_rd && host_addr == RA_FIFO)),
        .head(eng_head),
        .count(count)
    );

    always_comb begin
        set_c.bus_rst = eng_bus_reset;
        set_c.bad_cmd = bad_cmd;
        set_c.disconn = eng_disconnect;
        set_c.svc_req = eng_service_req;
        set_c.parity  = eng_parity_err;
        set_c.gross   = eng_gross_err;
    end

    hcu_cause_latch #(.N(CAUSE_W)) u_causes (
        .clk(clk), .rst(rst),
        .set_i(set_c),
        .clr_i(chiprst || (host_rd && host_addr == RA_INTR)),
        .q(held)
    );

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= eng_phase;
    end

    assign irq      = |held;
    assign stat_reg = {irq, held.gross, held.parity, 2'b00, phase_q};
    assign intr_reg = {held.bus_rst, held.bad_cmd, held.disconn, held.svc_req, 4'b0000};

    always_comb begin
        case (reg_addr_e'(host_addr))
            RA_FIFO:     host_rdata = eng_head;
            RA_CMD_STAT: host_rdata = stat_reg;
            RA_INTR:     host_rdata = intr_reg;
            default:     host_rdata = 8'(count);
        endcase
    end
endmodule

// File: rtl/hcu_checker.sv
module hcu_checker #(
    parameter int unsigned FIFO_DEPTH = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       host_wr,
    input logic       host_rd,
    input logic [1:0] host_addr,
    input logic [7:0] host_wdata,
    input logic [7:0] host_rdata,
    input logic       irq,
    input logic [2:0] eng_phase,
    input logic       any_event,
    input logic       eng_cmd_valid,
    input logic       recov
);
    // R1: every engine pulse follows a command write
    a_r1_pulse_after_write: assert property (@(posedge clk) disable iff (rst)
        eng_cmd_valid |-> $past(host_wr && host_addr == 2'd1));

    // R8: recovery drops all commands except no-op
    a_r8_recovery_silent: assert property (@(posedge clk) disable iff (rst)
        (recov && host_wr && host_addr == 2'd1) |=> !eng_cmd_valid);

    // R2: flush outside recovery empties the FIFO
    a_r2_flush_empties: assert property (@(posedge clk) disable iff (rst)
        (!recov && host_wr && host_addr == 2'd1 && host_wdata == 8'h01 && host_rd == 1'b0)
        |=> (host_addr != 2'd3 || host_rdata == 8'd0));

    // R4: status phase field follows the engine phase one cycle later
    a_r4_phase_follows: assert property (@(posedge clk) disable iff (rst)
        (host_addr == 2'd1) |-> (host_rdata[2:0] == $past(eng_phase)));

    // R9: count never exceeds depth
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (host_addr == 2'd3) |-> (host_rdata <= 8'(FIFO_DEPTH)));

    // R7: a clean read of the interrupt register drops the interrupt
    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == 2'd2 && !host_wr && !any_event) |=> !irq);
endmodule

bind hcu_top hcu_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
    .eng_phase(eng_phase),
    .any_event(eng_bus_reset || eng_disconnect || eng_service_req ||
               eng_parity_err || eng_gross_err),
    .eng_cmd_valid(eng_cmd_valid),
    .recov(recov)
);

// File: tb/test_hcu_top.sv
module test_hcu_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 0, host_rd = 0;
    logic [1:0] host_addr = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic       irq;
    logic [2:0] eng_phase = 0;
    logic       eng_bus_reset = 0, eng_disconnect = 0, eng_service_req = 0;
    logic       eng_parity_err = 0, eng_gross_err = 0, eng_pop = 0;
    logic [7:0] eng_head;
    logic       eng_cmd_valid;
    logic [6:0] eng_cmd_code;
    logic       eng_cmd_dma;

    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hcu_top #(.FIFO_DEPTH(16)) i_hcu_top (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic hread(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); host_rd = 1; host_addr = a; #1 d = host_rdata;
        @(negedge clk); host_rd = 0;
    endtask

    task automatic clear_all();
        logic [7:0] d;
        hread(2'd2, d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R11 irq", {7'd0, irq}, 8'd0);
        chk("R11 cmd_valid", {7'd0, eng_cmd_valid}, 8'd0);
        hread(2'd3, d); chk("R11 count", d, 8'd0);
        hread(2'd1, d); chk("R11 status", d, 8'd0);
    endtask

    task automatic t_engine_cmds();
        hwrite(2'd1, 8'h10);
        chk("R1 valid 10", {7'd0, eng_cmd_valid}, 8'd1);
        chk("R1 code 10", {1'b0, eng_cmd_code}, 8'h10);
        chk("R1 dma 10", {7'd0, eng_cmd_dma}, 8'd0);
        @(negedge clk);
        chk("R1 single cycle", {7'd0, eng_cmd_valid}, 8'd0);
        hwrite(2'd1, 8'h90);
        chk("R1 code 90", {eng_cmd_dma, eng_cmd_code}, 8'h90);
        hwrite(2'd1, 8'h41);
        chk("R1 code 41", {eng_cmd_valid, eng_cmd_code}, 8'hC1);
    endtask

    task automatic t_quiet_cmds();
        logic [7:0] d;
        hwrite(2'd1, 8'h00);
        chk("R2 nop no pulse", {7'd0, eng_cmd_valid}, 8'd0);
        hwrite(2'd0, 8'hA1); hwrite(2'd0, 8'hA2); hwrite(2'd0, 8'hA3);
        hread(2'd3, d); chk("R10 count 3", d, 8'd3);
        hwrite(2'd1, 8'h01);
        chk("R2 flush no pulse", {7'd0, eng_cmd_valid}, 8'd0);
        hread(2'd3, d); chk("R2 flush count", d, 8'd0);
        chk("R10 head empty", eng_head, 8'd0);
    endtask

    task automatic t_illegal();
        logic [7:0] d;
        hwrite(2'd1, 8'hFF);
        chk("R3 irq", {7'd0, irq}, 8'd1);
        chk("R3 no pulse", {7'd0, eng_cmd_valid}, 8'd0);
        hread(2'd1, d); chk("R3 status bit7", d, 8'h80);
        hread(2'd2, d); chk("R3 int bit6", d, 8'h40);
        chk("R7 irq cleared", {7'd0, irq}, 8'd0);
        hread(2'd2, d); chk("R7 int cleared", d, 8'h00);
    endtask

    task automatic t_phase();
        logic [7:0] d;
        for (int p = 0; p < 8; p++) begin
            @(negedge clk); eng_phase = 3'(p);
            hread(2'd1, d); chk("R4 phase", d, 8'(p));
        end
        @(negedge clk); eng_phase = 3'd0;
    endtask

    task automatic t_errors();
        logic [7:0] d;
        @(negedge clk); eng_parity_err = 1;
        @(negedge clk); eng_parity_err = 0;
        chk("R5 parity irq", {7'd0, irq}, 8'd1);
        hread(2'd1, d); chk("R5 parity status", d, 8'hA0);
        clear_all();
        hread(2'd1, d); chk("R7 parity cleared", d, 8'h00);
        @(negedge clk); eng_gross_err = 1; eng_phase = 3'd3;
        @(negedge clk); eng_gross_err = 0;
        hread(2'd1, d); chk("R5 gross status", d, 8'hC3);
        clear_all();
        @(negedge clk); eng_phase = 3'd0;
    endtask

    task automatic t_int_causes();
        logic [7:0] d;
        @(negedge clk); eng_bus_reset = 1;
        @(negedge clk); eng_bus_reset = 0;
        hread(2'd2, d); chk("R6 bus reset bit7", d, 8'h80);
        @(negedge clk); eng_disconnect = 1; eng_service_req = 1;
        @(negedge clk); eng_disconnect = 0; eng_service_req = 0;
        chk("R6 irq", {7'd0, irq}, 8'd1);
        hread(2'd2, d); chk("R6 disc+svc bits", d, 8'h30);
    endtask

    task automatic t_clear_race();
        logic [7:0] d;
        @(negedge clk); eng_bus_reset = 1;
        @(negedge clk); eng_bus_reset = 0;
        @(negedge clk); host_rd = 1; host_addr = 2'd2; eng_disconnect = 1;
        #1 d = host_rdata; chk("R7 read value", d, 8'h80);
        @(negedge clk); host_rd = 0; eng_disconnect = 0;
        chk("R7 race irq kept", {7'd0, irq}, 8'd1);
        hread(2'd2, d); chk("R7 race survivor", d, 8'h20);
    endtask

    task automatic t_chip_reset();
        logic [7:0] d;
        hwrite(2'd0, 8'h11); hwrite(2'd0, 8'h22);
        @(negedge clk); eng_service_req = 1;
        @(negedge clk); eng_service_req = 0;
        hwrite(2'd1, 8'h02);
        chk("R8 chip reset no pulse", {7'd0, eng_cmd_valid}, 8'd0);
        chk("R8 causes cleared", {7'd0, irq}, 8'd0);
        hread(2'd3, d); chk("R8 fifo emptied", d, 8'd0);
        hwrite(2'd1, 8'h10);
        chk("R8 ignored in recovery", {7'd0, eng_cmd_valid}, 8'd0);
        hwrite(2'd1, 8'hFF);
        chk("R8 bad ignored in recovery", {7'd0, irq}, 8'd0);
        hwrite(2'd0, 8'h33);
        hwrite(2'd1, 8'h01);
        hread(2'd3, d); chk("R8 flush ignored in recovery", d, 8'd1);
        hwrite(2'd1, 8'h00);
        hwrite(2'd1, 8'h11);
        chk("R8 accepted after nop", {eng_cmd_valid, eng_cmd_code}, 8'h91);
        hwrite(2'd1, 8'h01);
    endtask

    task automatic t_fifo();
        logic [7:0] d;
        for (int i = 0; i < 18; i++) hwrite(2'd0, 8'h40 + 8'(i));
        hread(2'd3, d); chk("R9 full count", d, 8'd16);
        chk("R10 head", eng_head, 8'h40);
        hread(2'd0, d); chk("R9 pop first", d, 8'h40);
        @(negedge clk); eng_pop = 1;
        @(negedge clk); eng_pop = 0;
        chk("R9 engine pop order", eng_head, 8'h42);
        for (int i = 2; i < 16; i++) begin
            hread(2'd0, d); chk("R9 order", d, 8'h40 + 8'(i));
        end
        hread(2'd3, d); chk("R9 drained", d, 8'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_engine_cmds();
        t_quiet_cmds();
        t_illegal();
        t_phase();
        t_errors();
        t_int_causes();
        t_clear_race();
        t_chip_reset();
        t_fifo();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule